// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines. It holds each accepted request until the processor takes it, and it tells the processor when a request should be serviced. Software reaches it through a byte-wide register port with two addresses.

After reset, software writes a short configuration sequence. A byte at address 0 with bit 4 set starts the sequence. Later bytes at address 1 supply the vector base, then the cascade map, then the mode byte. The flags in the opening byte decide whether the last two are expected. After that, address 1 writes load the mask, and address 0 writes carry end-of-interrupt and read-control commands.

Only unmasked rising edges on the request lines are latched. The highest-numbered line wins. Service is tracked per line, and a line is only forwarded when nothing at or above it is in service. The processor sees a one-clock interrupt pulse. When it strobes acknowledge, the controller returns the base ORed with the winning line number. If that line is marked as fed by a secondary controller, the block raises a flag instead, so that the secondary supplies the vector.

Top module: `intc8_top`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0x00, the address 0 read shows pending requests, the configuration step is idle, auto-EOI is off and `int_pulse` is low.
- R2: `reg_rdata` is combinational. With `reg_addr`=1 it shows the mask. With `reg_addr`=0 it shows the pending register when the read select is "pending" and the in-service register otherwise.
- R3: A write to address 0 with bit 4 set clears the mask and moves the step to 1. Bit 1 = 0 selects cascade mode and bit 1 = 1 selects single mode. Bit 0 = 1 announces a mode byte. Bit 0 = 0 turns auto-EOI off.
- R4: At step 1 an address 1 write keeps bits 7:3 as the vector base. In single mode it also clears `cas_cfg` and returns the step to 0. In cascade mode it advances the step to 2.
- R5: At step 2 an address 1 write is stored in `cas_cfg`. A primary stores the full byte. A secondary stores bits 2:0 with the upper bits zero. The step then goes to 3 if a mode byte was announced and to 0 otherwise. At step 3, bit 1 of the byte sets auto-EOI and the step returns to 0. At step 0 an address 1 write loads the mask.
- R6: An address 0 write with bits 4:3 = 01 and bit 1 = 1 sets the read select from bit 0 (1 = pending, 0 = in-service). With bit 1 = 0 the select is unchanged.
- R7: A 0-to-1 transition of `irq_in[i]` sets pending bit i when mask bit i is 0. A transition on a masked line is dropped and is not recovered by unmasking later. A line held high sets nothing further.
- R8: When an unmasked rising edge is latched on line L, `int_pulse` goes high in the next cycle if, after that cycle's updates, no in-service bit is set at L or above. Otherwise the pulse stays low.
- R9: While `int_ack` is high and a request is pending, `int_vector` equals the base ORed with the highest pending line. At that edge the pending bit clears and, with auto-EOI off, its in-service bit sets. When nothing is pending, `int_ack` changes no state.
- R10: In a primary, `vec_from_sec` is high during an acknowledge exactly when the `cas_cfg` bit of the winning line is set. It is never high outside an acknowledge of a pending request.
- R11: An address 0 write with bits 4:3 = 00 is an EOI command. Bits 7:5 = 001 clear the highest set in-service bit. Bits 7:5 = 011 clear the in-service bit numbered by bits 2:0. Every other bits 7:5 value changes nothing.
- R12: After any EOI, including the automatic one at an acknowledge, if pending bits remain and no in-service bit is set at or above the highest pending line, `int_pulse` is high in the next cycle.
- R13: With auto-EOI on, an acknowledge clears the pending bit without setting an in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register port address (0 or 1) |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_pulse | output | 1 | One-clock interrupt request to the processor |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| int_vector | output | 8 | Vector, valid while `int_ack` is high |
| vec_from_sec | output | 1 | The secondary controller supplies this vector |
| cas_cfg | output | 8 | Stored cascade map (primary) or ID (secondary) |

## Verification
The bench builds the block as a primary (`IS_PRIMARY` = 1). This brings the full-byte cascade map and the secondary-vector flag within reach, and it runs cascade, single and auto-EOI setups back to back. In that build the secondary path, which stores only an ID and never raises the flag, is only elaborated. Priority blocking by a higher in-service line, masked edges that are dropped, and interrupts raised again after both written and automatic EOIs are all driven and compared against a behavioural model on every clock.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  localparam int NLINES = 8;
  localparam int IDXW   = $clog2(NLINES);
  localparam int DW     = 8;
  localparam int BASEW  = DW - IDXW;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } cfg_step_e;

  // index of highest set bit, zero when none
  function automatic logic [IDXW-1:0] top_index(input logic [NLINES-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < NLINES; i++)
      if (v[i]) r = IDXW'(i);
    return r;
  endfunction

  // true when no bit at position idx or above is set
  function automatic logic clear_from(input logic [NLINES-1:0] v,
                                      input logic [IDXW-1:0] idx);
    return (v >> idx) == '0;
  endfunction
endpackage

// File: rtl/intc8_cfg.sv
module intc8_cfg
  import intc8_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [NLINES-1:0] imr,
  output logic [BASEW-1:0]  base,
  output logic [DW-1:0]     cas_map,
  output logic              auto_eoi,
  output logic              rd_pend,
  output logic              eoi_req,
  output logic              eoi_spec,
  output logic [IDXW-1:0]   eoi_line
);
  cfg_step_e         step_q, step_n;
  logic [NLINES-1:0] imr_q, imr_n;
  logic [BASEW-1:0]  base_q, base_n;
  logic [DW-1:0]     map_q, map_n, map_w;
  logic              auto_q, auto_n, rdp_q, rdp_n, casc_q, casc_n, four_q, four_n;
  logic              is_init, is_op, is_rdc, is_data;

  generate
    if (IS_PRIMARY) begin : g_pri
      assign map_w = wdata;
    end else begin : g_sec
      assign map_w = {{(DW-IDXW){1'b0}}, wdata[IDXW-1:0]};
    end
  endgenerate

  always_comb begin
    is_init = wr_en && !addr && wdata[4];
    is_op   = wr_en && !addr && (wdata[4:3] == 2'b00);
    is_rdc  = wr_en && !addr && (wdata[4:3] == 2'b01);
    is_data = wr_en && addr;

    eoi_req  = is_op && ((wdata[7:5] == 3'b001) || (wdata[7:5] == 3'b011));
    eoi_spec = wdata[6];
    eoi_line = wdata[IDXW-1:0];

    step_n = step_q;
    imr_n  = imr_q;
    base_n = base_q;
    map_n  = map_q;
    auto_n = auto_q;
    rdp_n  = rdp_q;
    casc_n = casc_q;
    four_n = four_q;

    if (is_init) begin
      imr_n  = '0;
      casc_n = !wdata[1];
      four_n = wdata[0];
      if (!wdata[0]) auto_n = 1'b0;
      step_n = STEP_BASE;
    end else if (is_rdc) begin
      if (wdata[1]) rdp_n = wdata[0];
    end else if (is_data) begin
      unique case (step_q)
        STEP_IDLE: imr_n = wdata;
        STEP_BASE: begin
          base_n = wdata[DW-1:IDXW];
          if (casc_q) step_n = STEP_CASC;
          else begin
            map_n  = '0;
            step_n = STEP_IDLE;
          end
        end
        STEP_CASC: begin
          map_n  = map_w;
          step_n = four_q ? STEP_MODE : STEP_IDLE;
        end
        STEP_MODE: begin
          auto_n = wdata[1];
          step_n = STEP_IDLE;
        end
        default: step_n = STEP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_IDLE;
      imr_q  <= '0;
      base_q <= '0;
      map_q  <= '0;
      auto_q <= 1'b0;
      rdp_q  <= 1'b1;
      casc_q <= 1'b0;
      four_q <= 1'b0;
    end else if (wr_en) begin
      step_q <= step_n;
      imr_q  <= imr_n;
      base_q <= base_n;
      map_q  <= map_n;
      auto_q <= auto_n;
      rdp_q  <= rdp_n;
      casc_q <= casc_n;
      four_q <= four_n;
    end
  end

  assign imr      = imr_q;
  assign base     = base_q;
  assign cas_map  = map_q;
  assign auto_eoi = auto_q;
  assign rd_pend  = rdp_q;
endmodule

// File: rtl/intc8_core.sv
module intc8_core
  import intc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NLINES-1:0] imr,
  input  logic              auto_eoi,
  input  logic              ack,
  input  logic              eoi_req,
  input  logic              eoi_spec,
  input  logic [IDXW-1:0]   eoi_line,
  output logic [NLINES-1:0] irr,
  output logic [NLINES-1:0] isr,
  output logic              pulse,
  output logic [IDXW-1:0]   sel_line,
  output logic              sel_valid
);
  logic [NLINES-1:0] pins_q, irr_q, isr_q, irr_n, isr_n;
  logic [NLINES-1:0] rise, ack_mask, eoi_mask;
  logic [IDXW-1:0]   eoi_idx;
  logic              take, eoi_evt, pulse_q, pulse_n;

  always_comb begin
    rise      = irq_in & ~pins_q & ~imr;
    sel_valid = |irr_q;
    sel_line  = top_index(irr_q);
    take      = ack && sel_valid;
    ack_mask  = take ? (NLINES'(1) << sel_line) : '0;
    eoi_idx   = eoi_spec ? eoi_line : top_index(isr_q);
    eoi_mask  = eoi_req ? (NLINES'(1) << eoi_idx) : '0;

    irr_n = (irr_q & ~ack_mask) | rise;
    if (auto_eoi) isr_n = isr_q & ~eoi_mask & ~ack_mask;
    else          isr_n = (isr_q & ~eoi_mask) | ack_mask;

    eoi_evt = eoi_req || (take && auto_eoi);
    pulse_n = ((|rise) && clear_from(isr_n, top_index(rise))) ||
              (eoi_evt && (|irr_n) && clear_from(isr_n, top_index(irr_n)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= '0;
      irr_q   <= '0;
      isr_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pins_q  <= irq_in;
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      pulse_q <= pulse_n;
    end
  end

  assign irr   = irr_q;
  assign isr   = isr_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/intc8_top.sv
module intc8_top
  import intc8_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NLINES-1:0] irq_in,
  output logic              int_pulse,
  input  logic              int_ack,
  output logic [DW-1:0]     int_vector,
  output logic              vec_from_sec,
  output logic [DW-1:0]     cas_cfg
);
  logic [NLINES-1:0] imr_w, irr_w, isr_w;
  logic [BASEW-1:0]  base_w;
  logic              auto_w, rdp_w, eoi_req_w, eoi_spec_w, sel_valid_w;
  logic [IDXW-1:0]   eoi_line_w, sel_line_w;

  intc8_cfg #(.IS_PRIMARY(IS_PRIMARY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .imr(imr_w), .base(base_w), .cas_map(cas_cfg),
    .auto_eoi(auto_w), .rd_pend(rdp_w), .eoi_req(eoi_req_w),
    .eoi_spec(eoi_spec_w), .eoi_line(eoi_line_w)
  );

  intc8_core u_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .imr(imr_w),
    .auto_eoi(auto_w), .ack(int_ack), .eoi_req(eoi_req_w),
    .eoi_spec(eoi_spec_w), .eoi_line(eoi_line_w), .irr(irr_w),
    .isr(isr_w), .pulse(int_pulse), .sel_line(sel_line_w),
    .sel_valid(sel_valid_w)
  );

  assign reg_rdata  = reg_addr ? imr_w : (rdp_w ? irr_w : isr_w);
  assign int_vector = {base_w, sel_line_w};

  generate
    if (IS_PRIMARY) begin : g_flag
      assign vec_from_sec = int_ack && sel_valid_w && cas_cfg[sel_line_w];
    end else begin : g_noflag
      assign vec_from_sec = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk
  import intc8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_addr,
  input logic              reg_wr,
  input logic [DW-1:0]     reg_wdata,
  input logic [NLINES-1:0] irq_in,
  input logic              int_pulse,
  input logic              int_ack,
  input logic              vec_from_sec,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] isr,
  input logic [NLINES-1:0] imr,
  input logic              auto_eoi
);
  logic [NLINES-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= irq_in;
  end

  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[4]) |=> (imr == '0)); // R3

  AST_MASKED_EDGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in & ~seen_q & imr & ~irr) != '0) |=>
      ((irr & $past(irq_in & ~seen_q & imr & ~irr)) == '0)); // R7

  AST_PULSE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |-> (irr != '0)); // R8

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && (irr != '0) && !auto_eoi && !reg_wr) |=>
      isr[$past(top_index(irr))]); // R9

  AST_SEC_FLAG_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_from_sec |-> (int_ack && (irr != '0))); // R10

  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && (reg_wdata[4:3] == 2'b00) &&
     (reg_wdata[7:5] == 3'b011) && !int_ack) |=>
      !isr[$past(reg_wdata[IDXW-1:0])]); // R11
endmodule

bind intc8_top intc8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .irq_in(irq_in), .int_pulse(int_pulse),
  .int_ack(int_ack), .vec_from_sec(vec_from_sec), .irr(irr_w),
  .isr(isr_w), .imr(imr_w), .auto_eoi(auto_w)
);

// File: tb/intc8_top_bench.sv
module intc8_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0, int_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] reg_rdata, int_vector, cas_cfg;
  logic int_pulse, vec_from_sec;

  always #10 clk = ~clk;

  intc8_top #(.IS_PRIMARY(1'b1)) u_intc8_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .int_pulse(int_pulse), .int_ack(int_ack), .int_vector(int_vector),
    .vec_from_sec(vec_from_sec), .cas_cfg(cas_cfg)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // next-cycle stimulus
  logic n_addr = 1'b0, n_wr = 1'b0, n_ack = 1'b0;
  logic [7:0] n_wd = 8'h00, n_irq = 8'h00;

  // reference model state
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_base = 0, m_map = 0, m_prev = 0;
  logic m_rdsel = 1, m_auto = 0, m_casc = 0, m_four = 0, m_pulse = 0;
  int m_step = 0;

  function automatic int hi_bit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [7:0] rise, nirr, nisr;
    int hp, idx, r, q;
    bit take, eoi, p;
    rise = n_irq & ~m_prev & ~m_imr;
    hp = hi_bit(m_irr);
    take = n_ack && (hp >= 0);
    eoi = 0; idx = 0;
    if (n_wr && !n_addr && n_wd[4:3] == 2'b00 &&
        (n_wd[7:5] == 3'b001 || n_wd[7:5] == 3'b011)) begin
      eoi = 1;
      if (n_wd[7:5] == 3'b011) idx = int'(n_wd[2:0]);
      else idx = (hi_bit(m_isr) < 0) ? 0 : hi_bit(m_isr);
    end
    nirr = m_irr;
    if (take) nirr[hp] = 1'b0;
    nirr = nirr | rise;
    nisr = m_isr;
    if (eoi) nisr[idx] = 1'b0;
    if (take) nisr[hp] = m_auto ? 1'b0 : 1'b1;
    p = 0;
    r = hi_bit(rise);
    if (r >= 0 && (nisr >> r) == 0) p = 1;
    if (eoi || (take && m_auto)) begin
      q = hi_bit(nirr);
      if (q >= 0 && (nisr >> q) == 0) p = 1;
    end
    if (n_wr && !n_addr) begin
      if (n_wd[4]) begin
        m_imr = 0; m_casc = !n_wd[1]; m_four = n_wd[0];
        if (!n_wd[0]) m_auto = 0;
        m_step = 1;
      end else if (n_wd[4:3] == 2'b01 && n_wd[1]) m_rdsel = n_wd[0];
    end else if (n_wr && n_addr) begin
      case (m_step)
        0: m_imr = n_wd;
        1: begin
          m_base = {n_wd[7:3], 3'b000};
          if (m_casc) m_step = 2;
          else begin m_map = 0; m_step = 0; end
        end
        2: begin m_map = n_wd; m_step = m_four ? 3 : 0; end
        default: begin m_auto = n_wd[1]; m_step = 0; end
      endcase
    end
    m_irr = nirr; m_isr = nisr; m_pulse = p; m_prev = n_irq;
  endtask

  // mode: 0 none, 1 rdata, 2 pulse, 3 vector, 4 sec flag, 5 cas_cfg
  task automatic tick(input int mode, input string tag, input logic [7:0] lit);
    int hp;
    @(negedge clk);
    reg_addr = n_addr; reg_wr = n_wr; reg_wdata = n_wd;
    int_ack = n_ack; irq_in = n_irq;
    #2;
    cmp("R2 rdata model", reg_rdata, n_addr ? m_imr : (m_rdsel ? m_irr : m_isr));
    cmp("R8 pulse model", {7'b0, int_pulse}, {7'b0, m_pulse});
    cmp("R5 cas_cfg model", cas_cfg, m_map);
    hp = hi_bit(m_irr);
    if (n_ack && hp >= 0) begin
      cmp("R9 vector model", int_vector, m_base | 8'(hp));
      cmp("R10 sec flag model", {7'b0, vec_from_sec}, {7'b0, m_map[hp]});
    end else
      cmp("R10 sec flag idle", {7'b0, vec_from_sec}, 8'h00);
    case (mode)
      1: cmp(tag, reg_rdata, lit);
      2: cmp(tag, {7'b0, int_pulse}, lit);
      3: cmp(tag, int_vector, lit);
      4: cmp(tag, {7'b0, vec_from_sec}, lit);
      5: cmp(tag, cas_cfg, lit);
      default: ;
    endcase
    @(posedge clk);
    model_step();
    n_wr = 0; n_ack = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    n_addr = a; n_wr = 1; n_wd = d; tick(0, "", 8'h00);
  endtask
  task automatic rd(input string tag, input logic a, input logic [7:0] e);
    n_addr = a; tick(1, tag, e);
  endtask
  task automatic idle();
    tick(0, "", 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd("R1 pending after reset", 0, 8'h00);
    rd("R1 mask after reset", 1, 8'h00);
    n_addr = 0; tick(2, "R1 no pulse after reset", 8'h00);

    // cascade setup with mode byte, map on line 2
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04);
    tick(5, "R5 cascade map stored", 8'h04);
    wr(1, 8'h00);
    wr(1, 8'h01);
    rd("R5 step0 loads mask", 1, 8'h01);

    n_irq = 8'h20; idle();
    n_addr = 0; tick(2, "R8 pulse after edge", 8'h01);
    rd("R7 edge latched", 0, 8'h20);
    n_irq = 8'h21; idle();
    rd("R7 masked edge ignored", 0, 8'h20);
    wr(1, 8'h00);
    rd("R7 masked edge not recovered", 0, 8'h20);

    n_irq = 8'h29; idle();
    n_addr = 0; tick(2, "R8 pulse line3", 8'h01);
    n_ack = 1; tick(3, "R9 vector line5", 8'h45);
    wr(0, 8'h0A);
    rd("R6 select in-service", 0, 8'h20);
    wr(0, 8'h08);
    rd("R6 bit1 clear keeps select", 0, 8'h20);

    n_irq = 8'h2B; idle();
    n_addr = 0; tick(2, "R8 blocked by higher service", 8'h00);
    wr(0, 8'h20);
    n_addr = 0; tick(2, "R12 pulse after EOI", 8'h01);
    rd("R11 nonspecific EOI cleared", 0, 8'h00);
    wr(0, 8'h0B);
    rd("R6 select pending", 0, 8'h0A);
    n_ack = 1; tick(3, "R9 vector line3", 8'h43);
    n_ack = 1; tick(3, "R9 vector line1", 8'h41);
    wr(0, 8'h0A);
    rd("R9 in-service set", 0, 8'h0A);
    wr(0, 8'h61);
    rd("R11 specific EOI line1", 0, 8'h08);
    wr(0, 8'h40);
    rd("R11 other code no change", 0, 8'h08);
    wr(0, 8'h20);
    n_addr = 0; tick(2, "R12 no pulse when nothing pending", 8'h00);
    rd("R11 last EOI", 0, 8'h00);

    n_irq = 8'h2F; idle();
    n_addr = 0; tick(2, "R8 pulse line2", 8'h01);
    n_ack = 1; tick(4, "R10 secondary supplies vector", 8'h01);
    wr(0, 8'h20);
    n_irq = 8'h00; idle();

    // cascade setup with auto-EOI
    wr(1, 8'h33);
    wr(0, 8'h11);
    rd("R3 init clears mask", 1, 8'h00);
    wr(1, 8'h80); wr(1, 8'h01); wr(1, 8'h02);
    tick(5, "R5 map line0", 8'h01);
    n_irq = 8'h40; idle();
    n_addr = 0; tick(2, "R8 pulse line6", 8'h01);
    n_irq = 8'h50; idle();
    n_ack = 1; tick(3, "R9 vector line6", 8'h86);
    n_addr = 0; tick(2, "R12 pulse after auto EOI", 8'h01);
    rd("R13 nothing in service", 0, 8'h00);
    n_ack = 1; tick(3, "R9 vector line4", 8'h84);
    rd("R13 still nothing in service", 0, 8'h00);

    // single mode, no mode byte
    n_irq = 8'h00; idle();
    wr(0, 8'h12); wr(1, 8'h28);
    tick(5, "R4 single mode clears map", 8'h00);
    wr(1, 8'hF0);
    rd("R4 step back to 0", 1, 8'hF0);
    n_irq = 8'h01; idle();
    n_addr = 0; tick(2, "R8 pulse line0", 8'h01);
    n_ack = 1; tick(3, "R9 vector single base", 8'h28);
    rd("R3 auto-EOI off after init", 0, 8'h01);
    n_ack = 1; idle();
    rd("R9 ack without pending", 0, 8'h01);
    wr(0, 8'h0B);
    rd("R9 pending empty", 0, 8'h00);
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule